// File: doc/BRIEF.md
# Depth-Banked Low-Activity Single-Port RAM

This block presents one logical single-port synchronous RAM to its user while building it out of several smaller physical banks. The logical address space is cut by depth: the top address bits choose one bank and the remaining bits address a word inside it. Each bank is a behavioural synchronous array with its own clock enable. Because every word lives whole inside a single bank, each access wakes exactly one bank and leaves the rest idle. This is the point of the wrapper: idle banks draw almost no dynamic power.

The user side has an access enable, a write/read select and an optional clock enable. The wrapper folds the user enables into the per-bank clock enables. When the clock-enable input is in use (`USE_CE` = 1), a bank's clock enable is the AND of the user enable, the user clock enable and that bank's decoder output. The enable on the bank itself is tied active. Reads have one cycle of latency. The bank-select bits of each read are registered, and on the next cycle they steer a read multiplexer. When a cycle does not read, the select register and the bank output both hold, so `rdata` keeps the last value that was read.

The default shape is a 4096 × 4 memory made of four 1024 × 4 banks. `NUM_BANKS` may be 1, 2 or 4. With one bank, the decoder and the multiplexer drop out.

Top module: `banked_ram`

## Requirements
- R1: After reset, `rdata` is 0 and `bank_active` is all zeros while `usr_en` is low.
- R2: During an access, bit b of `bank_active` is set, where b = `addr[11:10]` (the top two address bits in the default shape), and bank b is the bank accessed.
- R3: In no cycle is more than one bit of `bank_active` set.
- R4: When `usr_en` is 0, `bank_active` is all zeros, whatever the values of `addr`, `usr_we` and `usr_ce`.
- R5: With `usr_ce` = 0, `bank_active` is all zeros and a write cycle (`usr_en` = 1, `usr_we` = 1) leaves the stored word unchanged.
- R6: A cycle with `usr_en` = 1, `usr_ce` = 1 and `usr_we` = 1 stores `wdata` at `addr`. A cycle with `usr_en` = 1, `usr_ce` = 1 and `usr_we` = 0 makes the word at `addr` appear on `rdata` after the next rising clock edge. This also holds for reads issued back to back to different banks.
- R7: After a write cycle or an idle cycle, `rdata` still shows the last value that was read.
- R8: Words with the same in-bank offset in different banks are independent storage.
- R9: A read cycle with `usr_ce` = 0 leaves `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| usr_en | input | 1 | User access enable |
| usr_we | input | 1 | 1 = write, 0 = read |
| usr_ce | input | 1 | User clock enable (used when USE_CE = 1) |
| addr | input | ADDR_W (12) | Logical word address |
| wdata | input | DATA_W (4) | Write data |
| rdata | output | DATA_W (4) | Read data, one cycle after the read |
| bank_active | output | NUM_BANKS (4) | Per-bank clock enables as applied to the banks |

## Verification
The hardest case to reach from the ports is the read pipeline switching banks on every cycle. Here the registered select must follow each read exactly one cycle behind, while the bank read two cycles earlier still holds stale data that a wrong select would expose. The bench first fills every bank with values that depend on the address. It then issues back-to-back reads that rotate through all banks in both directions, checking each word one cycle after its read. Separate scenarios put reads with the clock enable held low, writes and idle cycles between valid reads, to show that `rdata` never moves to another bank's data.

// File: rtl/banked_ram_pkg.sv
package banked_ram_pkg;

  // Width of the bank-select field; at least one bit so vectors stay legal.
  function automatic int sel_bits(input int nb);
    return (nb > 1) ? $clog2(nb) : 1;
  endfunction

  // Address width inside one bank.
  function automatic int bank_addr_bits(input int aw, input int nb);
    return (nb > 1) ? aw - $clog2(nb) : aw;
  endfunction

endpackage

// File: rtl/bank_decoder.sv
module bank_decoder #(
  parameter int NB    = 4,
  parameter int SEL_W = 2
) (
  input  logic             access,
  input  logic [SEL_W-1:0] sel,
  output logic [NB-1:0]    ce
);

  generate
    if (NB == 1) begin : g_single
      logic unused_sel;
      assign unused_sel = ^sel;
      assign ce[0] = access;
    end else begin : g_multi
      for (genvar i = 0; i < NB; i++) begin : g_line
        assign ce[i] = access && (sel == SEL_W'(i));
      end
    end
  endgenerate

endmodule

// File: rtl/ram_bank.sv
module ram_bank #(
  parameter int DW = 4,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] dout
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          do_wr;
  logic          do_rd;
  logic [DW-1:0] dout_d;

  assign do_wr = ce && en && we;
  assign do_rd = ce && en && !we;

  // Array: no reset, written only while the clock enable is active.
  always_ff @(posedge clk) begin
    if (do_wr) begin
      mem[addr] <= wdata;
    end
  end

  // Output register next state: hold unless this bank performs a read.
  always_comb begin
    dout_d = dout;
    if (do_rd) begin
      dout_d = mem[addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else begin
      dout <= dout_d;
    end
  end

  // R7
  write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && we) |=> $stable(dout));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(dout));

endmodule

// File: rtl/read_mux.sv
module read_mux #(
  parameter int NB    = 4,
  parameter int DW    = 4,
  parameter int SEL_W = 2
) (
  input  logic [NB-1:0][DW-1:0] dout,
  input  logic [SEL_W-1:0]      sel_q,
  output logic [DW-1:0]         rdata
);

  generate
    if (NB == 1) begin : g_single
      logic unused_sel;
      assign unused_sel = ^sel_q;
      assign rdata = dout[0];
    end else begin : g_multi
      assign rdata = dout[sel_q];
    end
  endgenerate

endmodule

// File: rtl/banked_ram.sv
module banked_ram
  import banked_ram_pkg::*;
#(
  parameter int DATA_W    = 4,
  parameter int ADDR_W    = 12,
  parameter int NUM_BANKS = 4,
  parameter bit USE_CE    = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 usr_en,
  input  logic                 usr_we,
  input  logic                 usr_ce,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic [NUM_BANKS-1:0] bank_active
);

  localparam int SEL_W   = sel_bits(NUM_BANKS);
  localparam int BANK_AW = bank_addr_bits(ADDR_W, NUM_BANKS);

  logic                           ce_eff;
  logic                           access;
  logic                           rd_access;
  logic [SEL_W-1:0]               sel;
  logic [SEL_W-1:0]               sel_d;
  logic [SEL_W-1:0]               sel_q;
  logic [BANK_AW-1:0]             low_addr;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_dout;

  // Fold the user clock enable into the access term when it is in use.
  generate
    if (USE_CE) begin : g_ce
      assign ce_eff = usr_ce;
    end else begin : g_no_ce
      logic unused_ce;
      assign unused_ce = usr_ce;
      assign ce_eff    = 1'b1;
    end
  endgenerate

  assign access    = usr_en && ce_eff;
  assign rd_access = access && !usr_we;
  assign low_addr  = addr[BANK_AW-1:0];

  generate
    if (NUM_BANKS > 1) begin : g_sel
      assign sel = addr[ADDR_W-1 -: SEL_W];
    end else begin : g_nosel
      assign sel = '0;
    end
  endgenerate

  bank_decoder #(
    .NB    (NUM_BANKS),
    .SEL_W (SEL_W)
  ) u_dec (
    .access (access),
    .sel    (sel),
    .ce     (bank_active)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      ram_bank #(
        .DW (DATA_W),
        .AW (BANK_AW)
      ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (bank_active[b]),
        .en    (1'b1),
        .we    (usr_we),
        .addr  (low_addr),
        .wdata (wdata),
        .dout  (bank_dout[b])
      );
    end
  endgenerate

  // Registered select: advances only on a read, so rdata holds otherwise.
  always_comb begin
    sel_d = sel_q;
    if (rd_access) begin
      sel_d = sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else begin
      sel_q <= sel_d;
    end
  end

  read_mux #(
    .NB    (NUM_BANKS),
    .DW    (DATA_W),
    .SEL_W (SEL_W)
  ) u_mux (
    .dout  (bank_dout),
    .sel_q (sel_q),
    .rdata (rdata)
  );

  // R3
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_active));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !usr_en |-> (bank_active == '0));

  // R2
  bank_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access |-> ($countones(bank_active) == 1) && bank_active[sel]);

  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_access |=> $stable(rdata));

  generate
    if (USE_CE) begin : g_ce_chk
      // R5
      ce_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !usr_ce |-> (bank_active == '0));
    end
  endgenerate

endmodule

// File: tb/sim_banked_ram.sv
module sim_banked_ram;

  localparam int DW = 4;
  localparam int AW = 12;
  localparam int NB = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          usr_en;
  logic          usr_we;
  logic          usr_ce;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic [NB-1:0] bank_active;

  logic [DW-1:0] ref_mem [DEPTH];
  int n_chk;
  int n_fail;
  bit done;

  banked_ram #(.DATA_W(DW), .ADDR_W(AW), .NUM_BANKS(NB), .USE_CE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .usr_en(usr_en), .usr_we(usr_we),
    .usr_ce(usr_ce), .addr(addr), .wdata(wdata), .rdata(rdata),
    .bank_active(bank_active)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NB-1:0] onehot_of(input logic [AW-1:0] a);
    return NB'(1) << a[AW-1 -: 2];
  endfunction

  function automatic logic [DW-1:0] pattern(input int a);
    return DW'((a ^ (a >> 4) ^ (a >> 9)) + 3);
  endfunction

  task automatic idle_cycle();
    @(negedge clk);
    usr_en = 1'b0; usr_we = 1'b0; usr_ce = 1'b1;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit chk_dec);
    @(negedge clk);
    usr_en = 1'b1; usr_we = 1'b1; usr_ce = 1'b1; addr = a; wdata = d;
    #1;
    if (chk_dec) check("R2 write bank decode", 32'(bank_active), 32'(onehot_of(a)));
    ref_mem[a] = d;
  endtask

  task automatic read_chk(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    usr_en = 1'b1; usr_we = 1'b0; usr_ce = 1'b1; addr = a;
    #1;
    check("R2 read bank decode", 32'(bank_active), 32'(onehot_of(a)));
    @(negedge clk);
    usr_en = 1'b0;
    check(req, 32'(rdata), 32'(ref_mem[a]));
  endtask

  task automatic t_reset();
    usr_en = 1'b0; usr_we = 1'b0; usr_ce = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 rdata after reset", 32'(rdata), 32'h0);
    check("R1 bank_active after reset", 32'(bank_active), 32'h0);
    @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata after release", 32'(rdata), 32'h0);
  endtask

  task automatic t_fill();
    for (int a = 0; a < DEPTH; a++) begin
      do_write(AW'(a), pattern(a), (a % 97) == 0);
    end
    idle_cycle();
  endtask

  task automatic t_idle_quiet();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      usr_en = 1'b0; usr_we = k[0]; usr_ce = k[1];
      addr = AW'(k * 517);
      #1;
      check("R4 no bank with usr_en low", 32'(bank_active), 32'h0);
      check("R3 at most one bank", 32'($countones(bank_active) <= 1), 32'h1);
    end
  endtask

  task automatic t_alias();
    for (int b = 0; b < NB; b++) do_write({2'(b), 10'h155}, DW'(4'hA + b), 1'b1);
    for (int b = 0; b < NB; b++) read_chk({2'(b), 10'h155}, "R8 same offset other bank");
  endtask

  task automatic t_back2back();
    logic [AW-1:0] seq [8];
    for (int k = 0; k < 8; k++) begin
      seq[k] = {2'(k < 4 ? k : 7 - k), 10'(k * 37 + 5)};
    end
    @(negedge clk);
    usr_en = 1'b1; usr_we = 1'b0; usr_ce = 1'b1; addr = seq[0];
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      check("R6 back-to-back read data", 32'(rdata), 32'(ref_mem[seq[k-1]]));
      if (k < 8) addr = seq[k];
      else usr_en = 1'b0;
    end
  endtask

  task automatic t_hold();
    logic [DW-1:0] held;
    read_chk(12'h0C3, "R6 read before hold");
    held = ref_mem[12'h0C3];
    do_write(12'hF11, ~ref_mem[12'hF11], 1'b1);
    @(negedge clk);
    usr_en = 1'b0;
    check("R7 rdata after write", 32'(rdata), 32'(held));
    repeat (3) idle_cycle();
    check("R7 rdata after idle", 32'(rdata), 32'(held));
    read_chk(12'hF11, "R6 read of new write");
  endtask

  task automatic t_ce_gate();
    logic [DW-1:0] held;
    read_chk(12'h444, "R6 read before ce test");
    held = ref_mem[12'h444];
    @(negedge clk);
    usr_en = 1'b1; usr_we = 1'b1; usr_ce = 1'b0; addr = 12'h9A0; wdata = ~ref_mem[12'h9A0];
    #1;
    check("R5 no bank with usr_ce low", 32'(bank_active), 32'h0);
    @(negedge clk);
    usr_we = 1'b0; addr = 12'hC01;
    #1;
    check("R5 no bank on gated read", 32'(bank_active), 32'h0);
    @(negedge clk);
    usr_en = 1'b0; usr_ce = 1'b1;
    check("R9 gated read leaves rdata", 32'(rdata), 32'(held));
    read_chk(12'h9A0, "R5 gated write ignored");
  endtask

  task automatic t_random();
    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] a;
      a = AW'($urandom_range(0, DEPTH - 1));
      if ($urandom_range(0, 2) == 0) do_write(a, DW'($urandom), 1'b0);
      else read_chk(a, "R6 random read");
      if ($urandom_range(0, 4) == 0) idle_cycle();
    end
    idle_cycle();
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    t_reset();
    t_fill();
    t_idle_quiet();
    t_alias();
    t_back2back();
    t_hold();
    t_ce_gate();
    t_random();
    done = 1'b1;
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      finish_up();
    end
  end

endmodule